// File: doc/BRIEF.md
# Single-Channel Memory-to-Memory DMA Engine

This block is one DMA channel that copies data between two memory locations without processor help. Software sets up a source address, a destination address, a unit count and a channel control word through a small word-addressed register port. A separate operation register holds the controller-wide enable and two sticky error flags. The data units can be 1, 2, 4, 8 or 32 bytes wide.

Once both the global enable and the channel enable are set, the channel moves units one at a time over a request/grant memory port. In dual-address mode each unit is a read at the source followed by a write at the destination. In single-address mode each unit is a single read at the source, and the data goes directly to a device outside this block. The count register always holds the number of units still to move, so software can read the residue at any time. When the count reaches zero the channel sets a transfer-end flag, which can raise an interrupt.

Bad setups are caught before any memory access. These are a reserved size code, a misaligned address, or a non-zero destination in single-address mode. Any of them latches an address-error flag and drops the global enable. An NMI request does the same to its own flag.

Top module: `dma_single_channel`

## Requirements
- R1: After reset every register reads 0, `mem_req` is 0, and both interrupt outputs are 0.
- R2: The register port uses word index 0 for source, 1 for destination, 2 for count, 3 for control and 4 for operation. Control bits: bit0 channel enable, bit1 interrupt enable, bit2 transfer-end flag, bits 6:4 size code, bit8 single-address mode. Operation bits: bit0 global enable, bit1 NMI flag, bit2 address-error flag.
- R3: Size codes 0, 1, 2, 3 and 4 select units of 8, 1, 2, 4 and 32 bytes. In dual-address mode, each unit reads `mem_size`-coded data at the source and writes it at the destination. Both addresses then advance by the unit size in bytes.
- R4: The count decrements by one exactly when the write of a unit is granted (dual mode) or the read is granted (single mode). A count read always returns the units still to move.
- R5: When the count reaches zero the transfer-end flag is set. If the channel is started with a count of zero, the flag is set with no memory access.
- R6: `irq_end` is high exactly while the transfer-end flag, interrupt enable and channel enable are all set. Clearing the flag by writing 0 to it drops the interrupt.
- R7: A new unit starts only while global enable and channel enable are set and both the address-error and transfer-end flags are clear.
- R8: Starting with size code 5, 6 or 7 sets the address-error flag, clears global enable, makes no access and leaves the count unchanged.
- R9: A source address, or a dual-mode destination address, that is not a multiple of the unit size sets the address-error flag with no access.
- R10: In single-address mode each unit is one read at the source and no write. The destination register must be 0, otherwise the address-error flag is set. The destination register does not advance.
- R11: The address-error and NMI flags are cleared only by writing 0 to them, and writing 1 does not set them. Setting either flag clears global enable. `irq_err` follows the address-error flag.
- R12: While `mem_req` is high and not granted, it stays high next cycle with the same address.

Requirement-style register default: a control word of zero selects dual-address mode (bit8 = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| nmi_req | input | 1 | NMI event; sets NMI flag and clears global enable |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 3 | Size code of the access unit |
| mem_wdata | output | DW | Write data, unit in the low bytes |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | DW | Read data, valid with the grant |
| irq_end | output | 1 | Transfer-end interrupt |
| irq_err | output | 1 | Address-error interrupt |

## Verification
A wrong count shows up as a residue read that differs from the number of granted writes. It can be seen at the first negative edge after that grant, and later as an early or late `irq_end`. A wrong address step or size decode shows up as bytes missing or out of place in the destination region, or as a final source or destination register value that is off. Both are visible as soon as the transfer ends. A wrong error or enable state shows up as a memory request that should not be there, or as a missing one, within a few cycles of the channel enable being written.

// File: rtl/dce_pkg.sv
package dce_pkg;
   localparam int REG_DW = 32;

   // Register word indices
   localparam logic [2:0] RA_SRC  = 3'd0;
   localparam logic [2:0] RA_DST  = 3'd1;
   localparam logic [2:0] RA_CNT  = 3'd2;
   localparam logic [2:0] RA_CTRL = 3'd3;
   localparam logic [2:0] RA_OPR  = 3'd4;

   // Control word bit positions
   localparam int CB_DE     = 0;
   localparam int CB_IE     = 1;
   localparam int CB_TE     = 2;
   localparam int CB_SZ     = 4;
   localparam int CB_SINGLE = 8;

   // Operation word bit positions
   localparam int OB_DME  = 0;
   localparam int OB_NMIF = 1;
   localparam int OB_AE   = 2;

   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_READ  = 2'd1,
      SQ_WRITE = 2'd2
   } seq_state_t;

   // {valid, log2(bytes)} for a size code
   function automatic logic [3:0] unit_log2(input logic [2:0] code);
      case (code)
         3'd0:    unit_log2 = {1'b1, 3'd3};
         3'd1:    unit_log2 = {1'b1, 3'd0};
         3'd2:    unit_log2 = {1'b1, 3'd1};
         3'd3:    unit_log2 = {1'b1, 3'd2};
         3'd4:    unit_log2 = {1'b1, 3'd5};
         default: unit_log2 = {1'b0, 3'd0};
      endcase
   endfunction
endpackage

// File: rtl/dce_size_decode.sv
module dce_size_decode
   import dce_pkg::*;
#(
   parameter int AW = 32
) (
   input  logic [2:0]    code,
   output logic          valid,
   output logic [AW-1:0] step,
   output logic [AW-1:0] mask
);
   logic [3:0] dec;

   always_comb begin
      dec   = unit_log2(code);
      valid = dec[3];
      step  = AW'(1) << dec[2:0];
      mask  = step - AW'(1);
   end
endmodule

// File: rtl/dce_regs.sv
module dce_regs
   import dce_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [REG_DW-1:0] reg_wdata,
   output logic [REG_DW-1:0] reg_rdata,
   input  logic              nmi_req,
   input  logic              unit_done,
   input  logic              set_te,
   input  logic              set_ae,
   input  logic [AW-1:0]     step,
   output logic [AW-1:0]     src,
   output logic [AW-1:0]     dst,
   output logic [CW-1:0]     cnt,
   output logic [2:0]        size_code,
   output logic              single,
   output logic              de,
   output logic              ie,
   output logic              te,
   output logic              dme,
   output logic              ae,
   output logic              nmif
);
   logic w_src, w_dst, w_cnt, w_ctrl, w_opr;

   assign w_src  = reg_wr && (reg_addr == RA_SRC);
   assign w_dst  = reg_wr && (reg_addr == RA_DST);
   assign w_cnt  = reg_wr && (reg_addr == RA_CNT);
   assign w_ctrl = reg_wr && (reg_addr == RA_CTRL);
   assign w_opr  = reg_wr && (reg_addr == RA_OPR);

   // Address and count registers: hardware stepping wins over software
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src <= '0;
         dst <= '0;
         cnt <= '0;
      end else begin
         if (unit_done)  src <= src + step;
         else if (w_src) src <= reg_wdata[AW-1:0];

         if (unit_done && !single) dst <= dst + step;
         else if (w_dst)           dst <= reg_wdata[AW-1:0];

         if (unit_done)  cnt <= cnt - CW'(1);
         else if (w_cnt) cnt <= reg_wdata[CW-1:0];
      end
   end

   // Channel control word
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         de        <= 1'b0;
         ie        <= 1'b0;
         te        <= 1'b0;
         size_code <= 3'd0;
         single    <= 1'b0;
      end else begin
         if (w_ctrl) begin
            de        <= reg_wdata[CB_DE];
            ie        <= reg_wdata[CB_IE];
            te        <= te & reg_wdata[CB_TE];
            size_code <= reg_wdata[CB_SZ +: 3];
            single    <= reg_wdata[CB_SINGLE];
         end
         if (set_te) te <= 1'b1;
      end
   end

   // Operation register: sticky flags, clear-by-zero
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dme  <= 1'b0;
         nmif <= 1'b0;
         ae   <= 1'b0;
      end else begin
         if (w_opr) begin
            dme  <= reg_wdata[OB_DME];
            nmif <= nmif & reg_wdata[OB_NMIF];
            ae   <= ae & reg_wdata[OB_AE];
         end
         if (nmi_req) begin
            nmif <= 1'b1;
            dme  <= 1'b0;
         end
         if (set_ae) begin
            ae  <= 1'b1;
            dme <= 1'b0;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_SRC:  reg_rdata = REG_DW'(src);
         RA_DST:  reg_rdata = REG_DW'(dst);
         RA_CNT:  reg_rdata = REG_DW'(cnt);
         RA_CTRL: begin
            reg_rdata[CB_DE]        = de;
            reg_rdata[CB_IE]        = ie;
            reg_rdata[CB_TE]        = te;
            reg_rdata[CB_SZ +: 3]   = size_code;
            reg_rdata[CB_SINGLE]    = single;
         end
         RA_OPR: begin
            reg_rdata[OB_DME]  = dme;
            reg_rdata[OB_NMIF] = nmif;
            reg_rdata[OB_AE]   = ae;
         end
         default: reg_rdata = '0;
      endcase
   end

   AST_NMI_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      nmi_req |=> (nmif && !dme)); // R11
   AST_AE_NO_SW_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (!ae && !set_ae) |=> !ae); // R11
endmodule

// File: rtl/dce_seq.sv
module dce_seq
   import dce_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16,
   parameter int DW = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dme,
   input  logic          de,
   input  logic          ae,
   input  logic          te,
   input  logic          single,
   input  logic          unit_ok,
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic [AW-1:0] mask,
   input  logic [CW-1:0] cnt,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          unit_done,
   output logic          set_te,
   output logic          set_ae
);
   seq_state_t state, state_nx;
   logic [DW-1:0] stage;
   logic go, fault, last;

   always_comb begin
      go        = dme && de && !ae && !te;
      fault     = !unit_ok || (|(src & mask)) ||
                  (single ? (|dst) : (|(dst & mask)));
      last      = (cnt == CW'(1));
      state_nx  = state;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = src;
      unit_done = 1'b0;
      set_te    = 1'b0;
      set_ae    = 1'b0;
      case (state)
         SQ_IDLE: begin
            if (go) begin
               if (fault)             set_ae   = 1'b1;
               else if (cnt == '0)    set_te   = 1'b1;
               else                   state_nx = SQ_READ;
            end
         end
         SQ_READ: begin
            mem_req = 1'b1;
            if (mem_gnt) begin
               if (single) begin
                  unit_done = 1'b1;
                  set_te    = last;
                  state_nx  = SQ_IDLE;
               end else begin
                  state_nx  = SQ_WRITE;
               end
            end
         end
         SQ_WRITE: begin
            mem_req  = 1'b1;
            mem_we   = 1'b1;
            mem_addr = dst;
            if (mem_gnt) begin
               unit_done = 1'b1;
               set_te    = last;
               state_nx  = SQ_IDLE;
            end
         end
         default: state_nx = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SQ_IDLE;
         stage <= '0;
      end else begin
         state <= state_nx;
         if (state == SQ_READ && mem_gnt) stage <= mem_rdata;
      end
   end

   assign mem_wdata = stage;

   AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R12
   AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      ae |-> !mem_req); // R8
endmodule

// File: rtl/dma_single_channel.sv
module dma_single_channel
   import dce_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 16,
   parameter int DW = 256
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [31:0]   reg_wdata,
   output logic [31:0]   reg_rdata,
   input  logic          nmi_req,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [2:0]    mem_size,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_gnt,
   input  logic [DW-1:0] mem_rdata,
   output logic          irq_end,
   output logic          irq_err
);
   localparam int MAX_UNIT_BITS = 256;

   initial begin
      assert (AW >= 6 && AW <= REG_DW) else $error("AW out of range");
      assert (CW >= 2 && CW <= REG_DW) else $error("CW out of range");
      assert (DW >= MAX_UNIT_BITS && DW % 8 == 0) else $error("DW too narrow");
   end

   logic [AW-1:0] src_q, dst_q, step, mask;
   logic [CW-1:0] cnt_q;
   logic [2:0]    size_q;
   logic single_q, de_q, ie_q, te_q, dme_q, ae_q, nmif_q;
   logic unit_ok, unit_done, set_te, set_ae;

   dce_size_decode #(.AW(AW)) u_dec (
      .code  (size_q),
      .valid (unit_ok),
      .step  (step),
      .mask  (mask)
   );

   dce_regs #(.AW(AW), .CW(CW)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .nmi_req   (nmi_req),
      .unit_done (unit_done),
      .set_te    (set_te),
      .set_ae    (set_ae),
      .step      (step),
      .src       (src_q),
      .dst       (dst_q),
      .cnt       (cnt_q),
      .size_code (size_q),
      .single    (single_q),
      .de        (de_q),
      .ie        (ie_q),
      .te        (te_q),
      .dme       (dme_q),
      .ae        (ae_q),
      .nmif      (nmif_q)
   );

   dce_seq #(.AW(AW), .CW(CW), .DW(DW)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .dme       (dme_q),
      .de        (de_q),
      .ae        (ae_q),
      .te        (te_q),
      .single    (single_q),
      .unit_ok   (unit_ok),
      .src       (src_q),
      .dst       (dst_q),
      .mask      (mask),
      .cnt       (cnt_q),
      .mem_gnt   (mem_gnt),
      .mem_rdata (mem_rdata),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .unit_done (unit_done),
      .set_te    (set_te),
      .set_ae    (set_ae)
   );

   assign mem_size = size_q;
   assign irq_end  = te_q && ie_q && de_q;
   assign irq_err  = ae_q;

   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr & mask) == '0)); // R9
   AST_NO_MOVE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(dme_q && de_q && !te_q)); // R7
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_gnt && (mem_we || single_q)) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R4
   AST_TE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(te_q) |-> (cnt_q == '0)); // R5
   AST_AE_DROPS_DME: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ae_q) |-> !dme_q); // R11
   AST_SINGLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (single_q && mem_req) |-> !mem_we); // R10
endmodule

// File: tb/sim_dma_single_channel.sv
`timescale 1ns/1ps
module sim_dma_single_channel;
   localparam int AW = 32;
   localparam int CW = 16;
   localparam int DW = 256;
   localparam logic [2:0] A_SRC = 3'd0, A_DST = 3'd1, A_CNT = 3'd2, A_CTRL = 3'd3, A_OPR = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = 3'd0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          nmi_req = 1'b0;
   logic          mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [2:0]    mem_size;
   logic [DW-1:0] mem_wdata;
   logic          mem_gnt = 1'b0;
   logic [DW-1:0] mem_rdata = '0;
   logic          irq_end, irq_err;

   int n_checks = 0, n_err = 0;
   int n_rd = 0, n_wr = 0;
   int hold_bad = 0, hold_seen = 0;
   int gcyc = 0, tick = 0;
   logic [7:0] mem [0:1023];
   logic pend = 1'b0;
   logic [AW-1:0] pend_addr = '0;

   always #4 clk = ~clk;

   dma_single_channel #(.AW(AW), .CW(CW), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_req(nmi_req),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .irq_end(irq_end), .irq_err(irq_err)
   );

   function automatic int nbytes(input logic [2:0] c);
      case (c)
         3'd0: return 8;
         3'd1: return 1;
         3'd2: return 2;
         3'd3: return 4;
         3'd4: return 32;
         default: return 0;
      endcase
   endfunction

   function automatic logic [7:0] pat(input int a);
      return 8'((a * 7 + 3) % 256);
   endfunction

   // Memory model: grant pattern and read data at negedge
   always @(negedge clk) begin
      gcyc++;
      mem_gnt = mem_req && (gcyc % 3 != 0);
      mem_rdata = '0;
      if (mem_req && !mem_we)
         for (int i = 0; i < nbytes(mem_size); i++)
            mem_rdata[8*i +: 8] = mem[(int'(mem_addr[9:0]) + i) % 1024];
   end

   // Handshake monitor and memory writes at posedge
   always @(posedge clk) begin
      if (rst_n) begin
         if (pend) begin
            hold_seen++;
            if (!mem_req || mem_addr != pend_addr) hold_bad++;
         end
         pend = mem_req && !mem_gnt;
         pend_addr = mem_addr;
         if (mem_req && mem_gnt) begin
            if (mem_we) begin
               n_wr++;
               for (int i = 0; i < nbytes(mem_size); i++)
                  mem[(int'(mem_addr[9:0]) + i) % 1024] = mem_wdata[8*i +: 8];
            end else begin
               n_rd++;
            end
         end
      end
   end

   always @(posedge clk) begin
      tick++;
      if (tick == 150000) begin
         n_checks++;
         n_err++;
         $display("FAIL watchdog (R1..all): actual %0d cycles expected completion earlier", tick);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
         $finish;
      end
   end

   task automatic chk(input string req, input longint act, input longint exp);
      n_checks++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1;
      reg_addr = a;
      reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_end(output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk);
         #1;
         if (irq_end) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      logic [31:0] v;
      bit ok;
      int bad;
      for (int i = 0; i < 1024; i++) mem[i] = pat(i);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         chk($sformatf("R1 reg %0d after reset", a), v, 0);
      end
      chk("R1 mem_req after reset", mem_req, 0);
      chk("R1 irq_end/irq_err after reset", {irq_end, irq_err}, 0);

      wr(A_OPR, 32'h1);
      rd(A_OPR, v);
      chk("R2 operation register global enable", v, 1);

      // R3/R4/R5/R6: sweep all valid sizes and counts 1..3
      for (int sz = 0; sz < 5; sz++) begin
         for (int n = 1; n <= 3; n++) begin
            int b;
            b = nbytes(3'(sz));
            for (int i = 0; i < 128; i++) mem[512 + i] = 8'h00;
            n_rd = 0;
            n_wr = 0;
            wr(A_SRC, 32'h20);
            wr(A_DST, 32'h200);
            wr(A_CNT, 32'(n));
            wr(A_CTRL, 32'((sz << 4) | 3));
            wait_end(ok);
            chk($sformatf("R5 end flag sz%0d n%0d", sz, n), ok, 1);
            bad = 0;
            for (int i = 0; i < n * b; i++)
               if (mem[512 + i] != pat(32 + i)) bad++;
            chk($sformatf("R3 copied bytes wrong sz%0d n%0d", sz, n), bad, 0);
            chk($sformatf("R3 byte past end sz%0d n%0d", sz, n), mem[512 + n * b], 0);
            chk($sformatf("R4 write grants sz%0d n%0d", sz, n), n_wr, n);
            chk($sformatf("R3 read grants sz%0d n%0d", sz, n), n_rd, n);
            rd(A_CNT, v);
            chk($sformatf("R4 final count sz%0d n%0d", sz, n), v, 0);
            rd(A_SRC, v);
            chk($sformatf("R3 source step sz%0d n%0d", sz, n), v, 32 + n * b);
            rd(A_DST, v);
            chk($sformatf("R3 dest step sz%0d n%0d", sz, n), v, 512 + n * b);
            rd(A_CTRL, v);
            chk($sformatf("R5 control readback sz%0d n%0d", sz, n), v, (sz << 4) | 7);
            wr(A_CTRL, 32'((sz << 4) | 2));
            #1;
            chk($sformatf("R6 irq drops after clear sz%0d n%0d", sz, n), irq_end, 0);
         end
      end

      // R4: residue tracks granted writes
      n_wr = 0;
      n_rd = 0;
      wr(A_SRC, 32'h40);
      wr(A_DST, 32'h300);
      wr(A_CNT, 32'd4);
      wr(A_CTRL, 32'h13);
      bad = 0;
      reg_addr = A_CNT;
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         #1;
         if (reg_rdata != 32'(4 - n_wr)) bad++;
         if (irq_end) break;
      end
      chk("R4 residue vs granted writes", bad, 0);
      chk("R4 residue run writes", n_wr, 4);
      wr(A_CTRL, 32'h0);

      // R5: zero count sets the flag with no access
      n_wr = 0;
      n_rd = 0;
      wr(A_CNT, 32'd0);
      wr(A_CTRL, 32'h13);
      idle(5);
      rd(A_CTRL, v);
      chk("R5 zero count end flag", v[2], 1);
      chk("R5 zero count accesses", n_rd + n_wr, 0);
      wr(A_CTRL, 32'h0);

      // R7: global enable off blocks, then releases
      wr(A_OPR, 32'h0);
      wr(A_SRC, 32'h20);
      wr(A_DST, 32'h200);
      wr(A_CNT, 32'd2);
      n_wr = 0;
      n_rd = 0;
      wr(A_CTRL, 32'h13);
      idle(20);
      chk("R7 no access with global enable off", n_rd + n_wr, 0);
      rd(A_CNT, v);
      chk("R7 count held with global enable off", v, 2);
      wr(A_OPR, 32'h1);
      wait_end(ok);
      chk("R7 runs after global enable", n_wr, 2);
      // end flag set with channel enable still on: must not restart
      n_wr = 0;
      n_rd = 0;
      wr(A_CNT, 32'd2);
      idle(20);
      chk("R7 no access while end flag set", n_rd + n_wr, 0);
      wr(A_CTRL, 32'h13);
      wait_end(ok);
      chk("R7 resumes after end flag cleared", n_wr, 2);
      wr(A_CTRL, 32'h0);

      // R8: reserved size codes
      for (int c = 5; c < 8; c++) begin
         n_wr = 0;
         n_rd = 0;
         wr(A_SRC, 32'h20);
         wr(A_DST, 32'h200);
         wr(A_CNT, 32'd2);
         wr(A_CTRL, 32'((c << 4) | 1));
         idle(10);
         rd(A_OPR, v);
         chk($sformatf("R8 code %0d sets error, drops enable", c), v, 4);
         chk($sformatf("R11 irq_err code %0d", c), irq_err, 1);
         chk($sformatf("R8 code %0d accesses", c), n_rd + n_wr, 0);
         rd(A_CNT, v);
         chk($sformatf("R8 code %0d count unchanged", c), v, 2);
         wr(A_CTRL, 32'h0);
         wr(A_OPR, 32'h1);
         rd(A_OPR, v);
         chk($sformatf("R11 error cleared by zero code %0d", c), v, 1);
      end

      // R9: misaligned source, then misaligned destination (4-byte units)
      for (int m = 0; m < 2; m++) begin
         n_wr = 0;
         n_rd = 0;
         wr(A_SRC, (m == 0) ? 32'h22 : 32'h20);
         wr(A_DST, (m == 0) ? 32'h200 : 32'h202);
         wr(A_CNT, 32'd1);
         wr(A_CTRL, 32'h31);
         idle(10);
         rd(A_OPR, v);
         chk($sformatf("R9 misaligned case %0d error", m), v, 4);
         chk($sformatf("R9 misaligned case %0d accesses", m), n_rd + n_wr, 0);
         wr(A_CTRL, 32'h0);
         wr(A_OPR, 32'h1);
      end

      // R10: single-address mode
      n_wr = 0;
      n_rd = 0;
      wr(A_SRC, 32'h30);
      wr(A_DST, 32'h0);
      wr(A_CNT, 32'd3);
      wr(A_CTRL, 32'h113);
      wait_end(ok);
      chk("R10 single mode ends", ok, 1);
      chk("R10 single mode reads", n_rd, 3);
      chk("R10 single mode writes", n_wr, 0);
      rd(A_SRC, v);
      chk("R10 single mode source step", v, 32'h33);
      rd(A_DST, v);
      chk("R10 single mode dest unchanged", v, 0);
      wr(A_CTRL, 32'h0);
      n_rd = 0;
      wr(A_DST, 32'h200);
      wr(A_CNT, 32'd1);
      wr(A_CTRL, 32'h111);
      idle(10);
      rd(A_OPR, v);
      chk("R10 single mode non-zero dest error", v, 4);
      chk("R10 single mode bad dest accesses", n_rd, 0);
      wr(A_CTRL, 32'h0);
      wr(A_OPR, 32'h1);

      // R11: flags cannot be set by software; NMI path
      wr(A_OPR, 32'h7);
      rd(A_OPR, v);
      chk("R11 writing ones does not set flags", v, 1);
      @(negedge clk);
      nmi_req = 1'b1;
      @(negedge clk);
      nmi_req = 1'b0;
      rd(A_OPR, v);
      chk("R11 NMI sets flag, drops enable", v, 2);
      wr(A_OPR, 32'h3);
      rd(A_OPR, v);
      chk("R11 NMI flag kept on write of one", v, 3);
      wr(A_OPR, 32'h1);
      rd(A_OPR, v);
      chk("R11 NMI flag cleared by zero", v, 1);

      // R12: request held until grant
      chk("R12 request dropped or moved before grant", hold_bad, 0);
      chk("R12 waits exercised", hold_seen > 0, 1);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end
endmodule